// File: doc/BRIEF.md
# Boundary-Scan Test Clock Timebase

This block turns the master oscillator into the boundary-scan test clock (TCK). The divide ratio is loaded once per stored test. A value N gives a TCK period of 2N master cycles, N low and N high. A ratio that changes while the clock runs is adopted only where a low phase begins, so no shortened pulse ever appears on TCK. Next to TCK the block gives single-cycle rise and fall enables in the master-clock domain, so shift logic never has to sample TCK itself.

The block has two down-counters, and both count generated TCK rising edges. The settling counter is loaded before a test first drives the scan bus. The 16-bit idle counter is loaded by the execution engine to hold the chain in the idle state for a commanded number of clocks. Each counter gives a one-cycle done pulse when it reaches zero.

The generator has three states: OFF, LOW and HIGH.
- OFF→LOW when the enable rises.
- LOW→HIGH when the low phase count ends.
- HIGH→LOW when the high phase count ends.
- LOW or HIGH→OFF when the enable drops.

Each counter has two states, IDLE and RUN.
- IDLE→RUN on a start with a nonzero count.
- RUN→IDLE when the last edge is counted.
- RUN→RUN on a restart with a nonzero count.
- RUN→IDLE on a restart with a zero count.

Top module: `tck_timebase`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, TCK, both edge enables and both done flags are 0.
- R2: With the enable held high and ratio N≥1 (an 8-bit unsigned value), TCK is high for exactly N cycles and low for exactly N cycles. The first low phase after enable lasts N cycles.
- R3: A loaded ratio of 0 behaves as 1, so TCK toggles every master cycle.
- R4: A ratio loaded during a high phase does not change that high phase. It takes effect from the next low phase onward.
- R5: The rise enable is 1 in exactly the first cycle TCK is high. The fall enable is 1 in exactly the first cycle TCK is low after a high phase. The two enables are never 1 together.
- R6: When the enable drops, TCK is 0 from the next cycle on and no rise enable occurs. If TCK was high, a fall enable marks the drop. On re-enable, TCK first rises after N low cycles.
- R7: After a settling start with count D>0, the settling done flag pulses for one cycle, in the cycle after the D-th rise enable seen after the start cycle.
- R8: A start with count 0 (on either counter) pulses that counter's done flag in the next cycle without waiting for TCK.
- R9: The 16-bit idle counter follows the same counting rule as R7 on its own inputs, independently of the settling counter.
- R10: A start given while a count is running abandons it. Counting restarts from the new value, and no done pulse comes from the abandoned count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Runs the TCK generator when 1 |
| div_load | input | 1 | Strobe capturing div_value as the next ratio |
| div_value | input | DIV_W | Half-period in master cycles (0 treated as 1) |
| delay_start | input | 1 | Loads and starts the settling counter |
| delay_count | input | DLY_W | Settling length in TCK cycles |
| idle_start | input | 1 | Loads and starts the idle counter |
| idle_count | input | IDLE_W | Idle length in TCK cycles |
| tck | output | 1 | Generated test clock |
| tck_rise | output | 1 | One-cycle enable at each TCK rising edge |
| tck_fall | output | 1 | One-cycle enable at each TCK falling edge |
| delay_done | output | 1 | One-cycle pulse at the end of the settling count |
| idle_done | output | 1 | One-cycle pulse at the end of the idle count |

## Verification
The bench builds the block with its defaults: an 8-bit ratio, 16-bit counters and a reset ratio of 1. The smallest ratios (0, 1 and 2) make single-cycle phases and back-to-back edge enables likely, and the bench takes TCK through them. A change from ratio 4 to ratio 2 in the middle of a high phase is also covered. With ratio 1, an idle count of several hundred finishes in a few hundred master cycles. Counts of zero, a restart in mid-count, and a disable during a high phase are also exercised.

// File: rtl/tck_pkg.sv
package tck_pkg;
    typedef enum logic [1:0] {
        GEN_OFF  = 2'd0,
        GEN_LOW  = 2'd1,
        GEN_HIGH = 2'd2
    } gen_state_t;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_t;
endpackage

// File: rtl/tck_divider.sv
module tck_divider
    import tck_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             div_load,
    input  logic [DIV_W-1:0] div_value,
    output logic             tck,
    output logic             tck_rise,
    output logic             tck_fall
);
    localparam logic [DIV_W-1:0] ONE     = DIV_W'(1);
    localparam logic [DIV_W-1:0] DEF_EFF = (DEF_DIV == 0) ? ONE : DIV_W'(DEF_DIV);

    gen_state_t       state, state_nx;
    logic [DIV_W-1:0] pend_div;
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] phase_cnt;
    logic             phase_end;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    assign phase_end = (phase_cnt == act_div - ONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GEN_OFF;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            GEN_OFF:  if (gen_en) state_nx = GEN_LOW;
            GEN_LOW:  if (!gen_en) state_nx = GEN_OFF;
                      else if (phase_end) state_nx = GEN_HIGH;
            GEN_HIGH: if (!gen_en) state_nx = GEN_OFF;
                      else if (phase_end) state_nx = GEN_LOW;
            default:  state_nx = GEN_OFF;
        endcase
    end

    // ratio capture and phase timing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_div  <= DEF_EFF;
            act_div   <= DEF_EFF;
            phase_cnt <= '0;
        end else begin
            if (div_load) pend_div <= clamp_div(div_value);
            if (state == GEN_OFF || (state == GEN_HIGH && state_nx == GEN_LOW))
                act_div <= pend_div;
            if (state == GEN_OFF || state_nx != state) phase_cnt <= '0;
            else                                       phase_cnt <= phase_cnt + ONE;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tck      <= 1'b0;
            tck_rise <= 1'b0;
            tck_fall <= 1'b0;
        end else begin
            tck      <= (state_nx == GEN_HIGH);
            tck_rise <= (state == GEN_LOW) && (state_nx == GEN_HIGH);
            tck_fall <= (state == GEN_HIGH) && (state_nx != GEN_HIGH);
        end
    end
endmodule

// File: rtl/tck_cycle_counter.sv
module tck_cycle_counter
    import tck_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] count,
    output logic         done
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_state_t   state, state_nx;
    logic [W-1:0] remain;
    logic         last_tick;

    assign last_tick = (state == CNT_RUN) && tick && (remain == ONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CNT_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            CNT_IDLE: if (start && count != '0) state_nx = CNT_RUN;
            CNT_RUN:  if (start) state_nx = (count == '0) ? CNT_IDLE : CNT_RUN;
                      else if (last_tick) state_nx = CNT_IDLE;
            default:  state_nx = CNT_IDLE;
        endcase
    end

    // remaining edges
    always_ff @(posedge clk) begin
        if (!rst_n)                          remain <= '0;
        else if (start)                      remain <= count;
        else if (state == CNT_RUN && tick)   remain <= remain - ONE;
    end

    // registered output
    always_ff @(posedge clk) begin
        if (!rst_n)     done <= 1'b0;
        else if (start) done <= (count == '0);
        else            done <= last_tick;
    end
endmodule

// File: rtl/tck_timebase.sv
module tck_timebase #(
    parameter int DIV_W   = 8,
    parameter int DLY_W   = 16,
    parameter int IDLE_W  = 16,
    parameter int DEF_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic              div_load,
    input  logic [DIV_W-1:0]  div_value,
    input  logic              delay_start,
    input  logic [DLY_W-1:0]  delay_count,
    input  logic              idle_start,
    input  logic [IDLE_W-1:0] idle_count,
    output logic              tck,
    output logic              tck_rise,
    output logic              tck_fall,
    output logic              delay_done,
    output logic              idle_done
);
    tck_divider #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
        .div_load(div_load), .div_value(div_value),
        .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall)
    );

    tck_cycle_counter #(.W(DLY_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .tick(tck_rise),
        .start(delay_start), .count(delay_count), .done(delay_done)
    );

    tck_cycle_counter #(.W(IDLE_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .tick(tck_rise),
        .start(idle_start), .count(idle_count), .done(idle_done)
    );
endmodule

// File: rtl/tck_timebase_chk.sv
module tck_timebase_chk #(
    parameter int DLY_W  = 16,
    parameter int IDLE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_en,
    input logic              delay_start,
    input logic [DLY_W-1:0]  delay_count,
    input logic              idle_start,
    input logic [IDLE_W-1:0] idle_count,
    input logic              tck,
    input logic              tck_rise,
    input logic              tck_fall,
    input logic              delay_done,
    input logic              idle_done
);
    // R6
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> !tck);
    // R5
    rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck_rise |-> tck);
    // R5
    rose_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> tck_rise);
    // R5
    edges_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tck_rise, tck_fall}) <= 1);
    // R5
    fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tck_fall |-> !tck);
    // R7
    settle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delay_done && !delay_start |=> !delay_done);
    // R8
    settle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delay_start && delay_count == '0 |=> delay_done);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_start && idle_count == '0 |=> idle_done);
    // R9
    idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_done && !idle_start |=> !idle_done);
endmodule

bind tck_timebase tck_timebase_chk #(.DLY_W(DLY_W), .IDLE_W(IDLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
    .delay_start(delay_start), .delay_count(delay_count),
    .idle_start(idle_start), .idle_count(idle_count),
    .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .delay_done(delay_done), .idle_done(idle_done)
);

// File: tb/tck_timebase_tb.sv
`timescale 1ns/1ps
module tck_timebase_tb;
    localparam int DIV_W = 8, DLY_W = 16, IDLE_W = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, gen_en = 1'b0, div_load = 1'b0;
    logic [DIV_W-1:0] div_value = '0;
    logic delay_start = 1'b0, idle_start = 1'b0;
    logic [DLY_W-1:0] delay_count = '0;
    logic [IDLE_W-1:0] idle_count = '0;
    logic tck, tck_rise, tck_fall, delay_done, idle_done;

    tck_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en),
        .div_load(div_load), .div_value(div_value),
        .delay_start(delay_start), .delay_count(delay_count),
        .idle_start(idle_start), .idle_count(idle_count),
        .tck(tck), .tck_rise(tck_rise), .tck_fall(tck_fall),
        .delay_done(delay_done), .idle_done(idle_done)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_lvl = 0, m_run = 0, m_left = 0, m_act = 1, m_pend = 1;
    bit  e_tck = 0, e_rise = 0, e_fall = 0;
    int  d_busy = 0, d_rem = 0, i_busy = 0, i_rem = 0;
    bit  e_dd = 0, e_id = 0;

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    always @(posedge clk) begin : model
        bit r_old;
        int np;
        if (!rst_n) begin
            m_lvl = 0; m_run = 0; m_left = 0; m_act = 1; m_pend = 1;
            e_tck = 0; e_rise = 0; e_fall = 0;
            d_busy = 0; d_rem = 0; i_busy = 0; i_rem = 0; e_dd = 0; e_id = 0;
        end else begin
            r_old = e_rise;
            e_dd = 0;
            if (delay_start) begin
                if (delay_count == 0) begin e_dd = 1; d_busy = 0; end
                else begin d_busy = 1; d_rem = int'(delay_count); end
            end else if (d_busy == 1 && r_old) begin
                if (d_rem == 1) begin e_dd = 1; d_busy = 0; end
                else d_rem--;
            end
            e_id = 0;
            if (idle_start) begin
                if (idle_count == 0) begin e_id = 1; i_busy = 0; end
                else begin i_busy = 1; i_rem = int'(idle_count); end
            end else if (i_busy == 1 && r_old) begin
                if (i_rem == 1) begin e_id = 1; i_busy = 0; end
                else i_rem--;
            end
            np = div_load ? eff(int'(div_value)) : m_pend;
            e_rise = 0; e_fall = 0;
            if (!gen_en) begin
                e_fall = (m_lvl == 1); m_lvl = 0; m_run = 0; m_act = m_pend;
            end else if (m_run == 0) begin
                m_run = 1; m_lvl = 0; m_act = m_pend; m_left = m_act;
            end else begin
                m_left--;
                if (m_left == 0) begin
                    m_lvl = 1 - m_lvl;
                    if (m_lvl == 0) m_act = m_pend;
                    m_left = m_act;
                    e_rise = (m_lvl == 1);
                    e_fall = (m_lvl == 0);
                end
            end
            m_pend = np;
            e_tck = (m_lvl == 1);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2", "tck", int'(tck), int'(e_tck));
            chk("R5", "tck_rise", int'(tck_rise), int'(e_rise));
            chk("R5", "tck_fall", int'(tck_fall), int'(e_fall));
            chk("R7", "delay_done", int'(delay_done), int'(e_dd));
            chk("R9", "idle_done", int'(idle_done), int'(e_id));
        end
    end

    task automatic load_div(int v);
        div_value = DIV_W'(v); div_load = 1'b1;
        @(negedge clk); div_load = 1'b0;
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!tck_rise);
    endtask

    task automatic meas_high(output int n);
        n = 0;
        while (tck && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic meas_low(output int n);
        n = 0;
        while (!tck && n < 1000) begin n++; @(negedge clk); end
    endtask

    // which: 0 settling, 1 idle
    task automatic run_count(bit which, int c, output int rises, output int waits);
        if (which) begin idle_count = IDLE_W'(c); idle_start = 1'b1; end
        else begin delay_count = DLY_W'(c); delay_start = 1'b1; end
        @(negedge clk);
        idle_start = 1'b0; delay_start = 1'b0;
        rises = 0; waits = 1;
        while (!(which ? idle_done : delay_done) && waits < 5000) begin
            if (tck_rise) rises++;
            @(negedge clk); waits++;
        end
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int n, r, w;
        repeat (5) @(negedge clk);
        chk("R1", "tck in reset", int'(tck), 0);
        chk("R1", "edges in reset", int'(tck_rise | tck_fall), 0);
        rst_n = 1'b1;
        chk("R1", "done flags after reset", int'(delay_done | idle_done), 0);

        // R2: ratio 3
        load_div(3);
        gen_en = 1'b1;
        wait_rise();
        meas_high(n); chk("R2", "high length ratio 3", n, 3);
        meas_low(n);  chk("R2", "low length ratio 3", n, 3);

        // R3: ratio 0 acts as 1
        load_div(0);
        meas_high(n);
        meas_low(n);  chk("R3", "low length ratio 0", n, 1);
        meas_high(n); chk("R3", "high length ratio 0", n, 1);

        // R4: reload during a high phase
        load_div(4);
        repeat (12) @(negedge clk);
        wait_rise();
        div_value = DIV_W'(2); div_load = 1'b1;
        n = 0;
        while (tck && n < 1000) begin n++; @(negedge clk); div_load = 1'b0; end
        chk("R4", "high phase keeps old ratio", n, 4);
        meas_low(n);  chk("R4", "next low uses new ratio", n, 2);
        meas_high(n); chk("R4", "next high uses new ratio", n, 2);

        // R6: disable in a high phase
        wait_rise();
        gen_en = 1'b0;
        @(negedge clk);
        chk("R6", "tck after disable", int'(tck), 0);
        chk("R6", "fall marks disable", int'(tck_fall), 1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R6", "no rise while off", int'(tck | tck_rise), 0);
        end
        gen_en = 1'b1;
        @(negedge clk);
        meas_low(n); chk("R6", "first low after enable", n, 2);

        // R7: settling count 5
        run_count(0, 5, r, w); chk("R7", "settling rises", r, 5);

        // R8: zero counts
        run_count(0, 0, r, w); chk("R8", "settling zero wait", w, 1);
        chk("R8", "settling zero rises", r, 0);
        run_count(1, 0, r, w); chk("R8", "idle zero wait", w, 1);

        // R9: idle counter at ratio 1
        load_div(1);
        repeat (10) @(negedge clk);
        run_count(1, 300, r, w); chk("R9", "idle rises", r, 300);
        run_count(1, 3, r, w);   chk("R9", "idle rises short", r, 3);

        // R10: restart mid-count
        delay_count = DLY_W'(10); delay_start = 1'b1;
        @(negedge clk); delay_start = 1'b0;
        r = 0;
        while (r < 3) begin
            if (tck_rise) r++;
            if (r < 3) @(negedge clk);
        end
        chk("R10", "no early done", int'(delay_done), 0);
        run_count(0, 4, r, w); chk("R10", "rises after restart", r, 4);
        repeat (30) @(negedge clk);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule